// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a synchronous static RAM whose inputs are all registered on the rising clock edge and whose read data passes through an output register. Each word is 64 bits wide and split into eight byte lanes. The depth is set by an address-width parameter; the full-size part would use 16 address bits. Separate data-in and data-out buses replace a bidirectional pin bus. An output-valid flag takes the place of the high-impedance state.

An access begins with one of two active-low address strobes. The processor strobe is masked when the primary enable is inactive, and it always starts a read. The controller strobe is not masked by the primary enable, but a controller strobe with the primary enable inactive deselects the device. Four secondary enables are looked at only on a strobe cycle. After a start, an advance input steps a four-beat burst address counter. The counter counts linearly or in interleaved order, depending on a mode pin. While advance is high the current address is reused, which inserts wait states.

A sleep input puts the device into retention. Strobes are not accepted on the two clock edges that follow the release of sleep. A strobe seen in that window raises a sticky protocol-error flag.

Top module: `pburst_sram`

## Requirements
- R1: After reset, `rvalid` is 0, `rdata` is all zero, `proto_err` is 0, and no burst is active.
- R2: A read accepted on clock edge k appears on `rdata` with `rvalid` high after edge k+1 and stays there for one cycle only.
- R3: When `cpu_strb_n` is low and `ce_n` is low, the start cycle is a read whatever the write controls are. A following cycle with both strobes high and `adv_n` high writes the same address, using the write controls sampled in that cycle.
- R4: When `ce_n` is high, `cpu_strb_n` is ignored. When `ctl_strb_n` is low and `ce_n` is high, the device deselects, so later continue cycles neither read nor write.
- R5: The secondary enables count only on a strobe cycle. A strobe with `ce_hi_a`=0, `ce_hi_b`=0, `ce_lo_a_n`=1 or `ce_lo_b_n`=1 deselects the device and writes nothing. On a continue cycle their values have no effect.
- R6: When `wr_all_n` is low, all eight lanes are written. Otherwise, when `byte_wr_n` is low, lane n (bits 8n+7:8n, n=0..7) is written when `lane_en_n[n]` is low. If no lane is selected, the cycle is a read.
- R7: The start address is s, and the burst index i starts at 0. On a continue cycle, `adv_n` low adds 1 to i and `adv_n` high keeps i. The two low address bits are (s+i) mod 4 when `mode_lin`=1 and s XOR i when `mode_lin`=0. The upper address bits stay fixed.
- R8: `oe_n` acts without a clock. While it is high, `rvalid` is 0 and `rdata` is zero. Write cycles never give `rvalid`.
- R9: While `sleep` is high, no access starts and any open burst ends. Memory contents are kept.
- R10: On the first two edges with `sleep` low after a `sleep`-high edge, both strobes are ignored. A strobe low on those edges sets `proto_err`, which stays set until reset. The third edge accepts strobes.
- R11: After four advances the burst index wraps, so the fifth beat reuses the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Retention sleep request |
| mode_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | AW | Word address |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| byte_wr_n | input | 1 | Qualifies per-lane enables, active low |
| lane_en_n | input | NBYTES | Per-lane write enables, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce_hi_a | input | 1 | Secondary enable, active high |
| ce_hi_b | input | 1 | Secondary enable, active high |
| ce_lo_a_n | input | 1 | Secondary enable, active low |
| ce_lo_b_n | input | 1 | Secondary enable, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| wdata | input | 8*NBYTES | Write data |
| rdata | output | 8*NBYTES | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |
| proto_err | output | 1 | Sticky strobe-during-recovery flag |

## Verification
The assertions check properties that hold on every cycle and need only the port history. These are: a valid output implies no sleep, no recovery window and no controller-strobe deselect at the issuing edge; a processor-strobe start always yields a read; the error flag stays set once raised and is raised only by a strobe; outputs are zero while not valid. The bench scenarios are needed for the properties that depend on data and addresses. They cover the burst order in both modes from every start offset, the wrap after four beats, wait states, the exact byte lanes each write-control pattern touches, and contents kept across sleep. They also check that a write issued after a processor strobe lands at the held address.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    BURST_INTERLEAVE = 2'd0,
    BURST_LINEAR     = 2'd1
  } burst_order_e;

  // Low burst address bits for start offset s and index i.
  function automatic logic [1:0] burst_low(input logic lin, input logic [1:0] s, input logic [1:0] i);
    burst_low = lin ? (s + i) : (s ^ i);
  endfunction
endpackage

// File: rtl/pbs_burst_ctr.sv
module pbs_burst_ctr #(
  parameter int AW = 10,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          mode_lin,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] op_addr
);
  logic [AW-1:0] base_q;
  logic [BB-1:0] cnt_q;
  logic [BB-1:0] idx;
  logic [BB-1:0] low;

  always_comb begin
    idx     = step ? cnt_q + BB'(1) : cnt_q;
    low     = mode_lin ? (base_q[BB-1:0] + idx) : (base_q[BB-1:0] ^ idx);
    op_addr = load ? ext_addr : {base_q[AW-1:BB], low};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= ext_addr;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_q + BB'(1);
    end
  end
endmodule

// File: rtl/pbs_access_ctl.sv
module pbs_access_ctl #(
  parameter int NBYTES     = 8,
  parameter int REC_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic              sec_ok,
  input  logic              wr_all_n,
  input  logic              byte_wr_n,
  input  logic [NBYTES-1:0] lane_en_n,
  output logic              load,
  output logic              step,
  output logic              op_rd,
  output logic              op_wr,
  output logic [NBYTES-1:0] wmask,
  output logic              proto_err
);
  localparam int RW = $clog2(REC_CYCLES + 1);

  logic          active_q;
  logic [RW-1:0] rec_q;
  logic          err_q;
  logic          blocked, p_raw, start_p, start_c, start, cont, op_v;

  always_comb begin
    blocked = sleep || (rec_q != '0);
    p_raw   = !cpu_strb_n && !ce_n;
    start_p = !blocked && p_raw;
    start_c = !blocked && !p_raw && !ctl_strb_n;
    start   = start_p || start_c;
    load    = start && !ce_n && sec_ok;
    cont    = !blocked && !start && active_q;
    step    = cont && !adv_n;
    if (!wr_all_n)       wmask = '1;
    else if (!byte_wr_n) wmask = ~lane_en_n;
    else                 wmask = '0;
    op_v    = load || cont;
    op_wr   = op_v && !start_p && (wmask != '0);
    op_rd   = op_v && !op_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rec_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      if (sleep)      active_q <= 1'b0;
      else if (start) active_q <= load;

      if (sleep)              rec_q <= RW'(REC_CYCLES);
      else if (rec_q != '0)   rec_q <= rec_q - RW'(1);

      if ((rec_q != '0) && !sleep && (!cpu_strb_n || !ctl_strb_n)) err_q <= 1'b1;
    end
  end

  assign proto_err = err_q;
endmodule

// File: rtl/pbs_lane_ram.sv
module pbs_lane_ram #(
  parameter int AW = 10,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rq
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rq <= mem[addr];
  end
endmodule

// File: rtl/pburst_sram.sv
module pburst_sram #(
  parameter int AW         = 10,
  parameter int NBYTES     = 8,
  parameter int REC_CYCLES = 2,
  localparam int DW        = NBYTES * pbs_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              mode_lin,
  input  logic [AW-1:0]     addr,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              adv_n,
  input  logic              wr_all_n,
  input  logic              byte_wr_n,
  input  logic [NBYTES-1:0] lane_en_n,
  input  logic              ce_n,
  input  logic              ce_hi_a,
  input  logic              ce_hi_b,
  input  logic              ce_lo_a_n,
  input  logic              ce_lo_b_n,
  input  logic              oe_n,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rvalid,
  output logic              proto_err
);
  localparam int LW = pbs_pkg::LANE_W;

  logic              sec_ok, load, step, op_rd, op_wr;
  logic [NBYTES-1:0] wmask;
  logic [AW-1:0]     op_addr;
  logic [DW-1:0]     ram_q;
  logic              rd_p1, rv_q;
  logic [DW-1:0]     dout_q;

  assign sec_ok = ce_hi_a && ce_hi_b && !ce_lo_a_n && !ce_lo_b_n;

  pbs_access_ctl #(.NBYTES(NBYTES), .REC_CYCLES(REC_CYCLES)) u_ctl (
    .clk(clk), .rst(rst), .sleep(sleep),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .adv_n(adv_n),
    .ce_n(ce_n), .sec_ok(sec_ok),
    .wr_all_n(wr_all_n), .byte_wr_n(byte_wr_n), .lane_en_n(lane_en_n),
    .load(load), .step(step), .op_rd(op_rd), .op_wr(op_wr),
    .wmask(wmask), .proto_err(proto_err)
  );

  pbs_burst_ctr #(.AW(AW), .BB(2)) u_ctr (
    .clk(clk), .rst(rst), .load(load), .step(step), .mode_lin(mode_lin),
    .ext_addr(addr), .op_addr(op_addr)
  );

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    pbs_lane_ram #(.AW(AW), .W(LW)) u_ram (
      .clk(clk),
      .we(op_wr && wmask[g]),
      .re(op_rd),
      .addr(op_addr),
      .wd(wdata[g*LW +: LW]),
      .rq(ram_q[g*LW +: LW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p1  <= 1'b0;
      rv_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      rd_p1 <= op_rd;
      rv_q  <= rd_p1;
      if (rd_p1) dout_q <= ram_q;
    end
  end

  assign rvalid = rv_q && !oe_n;
  assign rdata  = rvalid ? dout_q : '0;
endmodule

// File: rtl/pbs_chk.sv
module pbs_chk #(
  parameter int AW     = 10,
  parameter int NBYTES = 8,
  localparam int DW    = NBYTES * 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sleep,
  input logic          cpu_strb_n,
  input logic          ctl_strb_n,
  input logic          ce_n,
  input logic          ce_hi_a,
  input logic          ce_hi_b,
  input logic          ce_lo_a_n,
  input logic          ce_lo_b_n,
  input logic          oe_n,
  input logic [DW-1:0] rdata,
  input logic          rvalid,
  input logic          proto_err
);
  // R8: nothing shown while not valid
  a_r8_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata == '0));

  // R9: no result from an edge with sleep high
  a_r9_no_read_in_sleep: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> !$past(sleep, 2));

  // R10: no result from an edge inside the recovery window
  a_r10_no_read_in_recovery: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (!$past(sleep, 3) && !$past(sleep, 4)));

  // R10: error flag is sticky
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  // R10: error flag only raised by a strobe
  a_r10_err_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(proto_err) |-> $past(!cpu_strb_n || !ctl_strb_n));

  // R4: controller strobe with primary enable off gives no read
  a_r4_ctl_deselect: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> !($past(!ctl_strb_n, 2) && $past(ce_n, 2) && $past(cpu_strb_n, 2)));

  // R3: processor strobe start always reads
  a_r3_proc_reads: assert property (@(posedge clk) disable iff (rst)
    ($past(!cpu_strb_n && !ce_n && ce_hi_a && ce_hi_b && !ce_lo_a_n && !ce_lo_b_n && !sleep, 2)
     && !$past(sleep, 3) && !$past(sleep, 4)
     && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) && !$past(rst, 4) && !oe_n)
    |-> rvalid);
endmodule

bind pburst_sram pbs_chk #(.AW(AW), .NBYTES(NBYTES)) u_chk (.*);

// File: tb/pburst_sram_tb.sv
module pburst_sram_tb;
  localparam int AW = 4;
  localparam int NB = 8;
  localparam int DW = NB * 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep = 0, mode_lin = 0, cpu_strb_n = 1, ctl_strb_n = 1, adv_n = 1;
  logic wr_all_n = 1, byte_wr_n = 1, ce_n = 0, ce_hi_a = 1, ce_hi_b = 1;
  logic ce_lo_a_n = 0, ce_lo_b_n = 0, oe_n = 0;
  logic [NB-1:0] lane_en_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid, proto_err;

  int n_chk = 0, n_fail = 0;

  bit m_act = 0, m_err = 0, pv = 0;
  int m_cnt = 0, m_rec = 0;
  logic [AW-1:0] m_base = '0;
  logic [DW-1:0] pd = '0;
  logic [DW-1:0] shadow [DEPTH];

  always #2.5 clk = ~clk;

  pburst_sram #(.AW(AW), .NBYTES(NB), .REC_CYCLES(2)) u_dut (
    .clk(clk), .rst(rst), .sleep(sleep), .mode_lin(mode_lin), .addr(addr),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .byte_wr_n(byte_wr_n), .lane_en_n(lane_en_n),
    .ce_n(ce_n), .ce_hi_a(ce_hi_a), .ce_hi_b(ce_hi_b),
    .ce_lo_a_n(ce_lo_a_n), .ce_lo_b_n(ce_lo_b_n), .oe_n(oe_n),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .proto_err(proto_err)
  );

  task automatic check(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    pat = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0101_0101_0101_0101) ^ (64'(i) << 60);
  endfunction

  task automatic idle();
    cpu_strb_n = 1; ctl_strb_n = 1; adv_n = 1; wr_all_n = 1; byte_wr_n = 1;
    lane_en_n = '1; ce_n = 0; ce_hi_a = 1; ce_hi_b = 1; ce_lo_a_n = 0; ce_lo_b_n = 0;
  endtask

  // Reference model of one clock edge, then compare outputs after the edge.
  task automatic tick(input string tag);
    bit blk, praw, sp, st, sok, ld, cont, wr, rdv;
    int idx;
    logic [1:0] lo;
    logic [AW-1:0] oa;
    logic [NB-1:0] wm;
    logic [DW-1:0] rdd;
    blk  = sleep || (m_rec > 0);
    praw = !cpu_strb_n && !ce_n;
    sp   = !blk && praw;
    st   = sp || (!blk && !praw && !ctl_strb_n);
    sok  = !ce_n && ce_hi_a && ce_hi_b && !ce_lo_a_n && !ce_lo_b_n;
    ld   = st && sok;
    cont = !blk && !st && m_act;
    if (!wr_all_n) wm = '1; else if (!byte_wr_n) wm = ~lane_en_n; else wm = '0;
    if (ld) oa = addr;
    else begin
      idx = adv_n ? m_cnt : (m_cnt + 1) % 4;
      lo  = mode_lin ? 2'((int'(m_base[1:0]) + idx) % 4) : (m_base[1:0] ^ 2'(idx));
      oa  = {m_base[AW-1:2], lo};
    end
    wr  = (ld || cont) && !sp && (wm != '0);
    rdv = (ld || cont) && !wr;
    rdd = shadow[oa];
    if (wr) for (int b = 0; b < NB; b++) if (wm[b]) shadow[oa][b*8 +: 8] = wdata[b*8 +: 8];
    if (m_rec > 0 && !sleep && (!cpu_strb_n || !ctl_strb_n)) m_err = 1;
    if (sleep) m_rec = 2; else if (m_rec > 0) m_rec--;
    if (sleep) m_act = 0; else if (st) m_act = sok;
    if (ld) begin m_base = addr; m_cnt = 0; end
    else if (cont && !adv_n) m_cnt = (m_cnt + 1) % 4;
    @(posedge clk); #1;
    check(tag, "rvalid", DW'(rvalid), DW'(pv && !oe_n));
    check(tag, "rdata", rdata, (pv && !oe_n) ? pd : '0);
    check(tag, "proto_err", DW'(proto_err), DW'(m_err));
    pv = rdv; pd = rdd;
  endtask

  task automatic wr_ctl(input string tag, input int a, input logic [DW-1:0] d);
    idle(); ctl_strb_n = 0; wr_all_n = 0; addr = AW'(a); wdata = d; tick(tag);
    idle();
  endtask

  task automatic rd_ctl(input string tag, input int a);
    idle(); ctl_strb_n = 0; addr = AW'(a); tick(tag);
    idle(); tick(tag); tick(tag);
  endtask

  initial begin
    #(5 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset state
    check("R1", "rvalid", DW'(rvalid), '0);
    check("R1", "rdata", rdata, '0);
    check("R1", "proto_err", DW'(proto_err), '0);
    idle(); tick("R1"); tick("R1");

    // R6: full-word fill
    for (int i = 0; i < DEPTH; i++) wr_ctl("R6", i, pat(i));
    tick("R6");

    // R2 R7 R11: every start offset, both orders, five beats (last wraps)
    for (int m = 0; m < 2; m++) begin
      mode_lin = m[0];
      for (int s = 0; s < DEPTH; s++) begin
        idle(); cpu_strb_n = 0; addr = AW'(s); tick("R2");
        idle(); adv_n = 0;
        for (int k = 0; k < 4; k++) tick(k == 3 ? "R11" : "R7");
        idle(); tick("R7"); tick("R7");
      end
    end

    // R7: wait states via advance high
    mode_lin = 1;
    idle(); ctl_strb_n = 0; addr = 4'd6; tick("R7");
    idle(); tick("R7"); tick("R7"); adv_n = 0; tick("R7"); adv_n = 1; tick("R7");
    ctl_strb_n = 0; ce_n = 1; tick("R4"); idle(); tick("R4"); tick("R4");

    // R3: processor strobe reads despite write controls, then write at held address
    idle(); cpu_strb_n = 0; wr_all_n = 0; addr = 4'd9; wdata = 64'hFFFF_0000_FFFF_0000; tick("R3");
    idle(); wr_all_n = 0; wdata = 64'hA5A5_5A5A_C3C3_3C3C; tick("R3");
    idle(); tick("R3");
    rd_ctl("R3", 9);

    // R6: each byte lane alone, plus inert controls
    for (int n = 0; n < NB; n++) begin
      idle(); ctl_strb_n = 0; byte_wr_n = 0; lane_en_n = ~(NB'(1) << n);
      addr = 4'd3; wdata = ~(64'(n) * 64'h0101_0101_0101_0101); tick("R6");
      idle(); tick("R6");
      rd_ctl("R6", 3);
    end
    idle(); ctl_strb_n = 0; byte_wr_n = 1; lane_en_n = '0; addr = 4'd4; wdata = '0; tick("R6");
    idle(); ctl_strb_n = 0; byte_wr_n = 0; lane_en_n = '1; addr = 4'd4; tick("R6");
    idle(); tick("R6"); tick("R6");
    rd_ctl("R6", 4);

    // R4: processor strobe masked by primary enable
    idle(); cpu_strb_n = 0; ce_n = 1; addr = 4'd2; tick("R4");
    idle(); adv_n = 0; tick("R4"); tick("R4"); idle(); tick("R4");

    // R5: each failing secondary blocks the write
    for (int k = 0; k < 4; k++) begin
      idle(); ctl_strb_n = 0; wr_all_n = 0; addr = 4'd5; wdata = 64'hDEAD_BEEF_DEAD_BEEF;
      case (k) 0: ce_hi_a = 0; 1: ce_hi_b = 0; 2: ce_lo_a_n = 1; default: ce_lo_b_n = 1; endcase
      tick("R5");
      idle(); wr_all_n = 0; adv_n = 0; tick("R5");
      idle(); rd_ctl("R5", 5);
    end
    // R5: secondaries ignored on continue cycles
    idle(); cpu_strb_n = 0; addr = 4'd8; tick("R5");
    idle(); adv_n = 0; ce_hi_a = 0; ce_lo_b_n = 1; tick("R5"); tick("R5");
    idle(); tick("R5"); tick("R5");

    // R8: output enable without a clock
    rd_ctl("R8", 7);
    idle(); ctl_strb_n = 0; addr = 4'd7; tick("R8"); idle(); tick("R8");
    oe_n = 1; #1;
    check("R8", "rvalid oe off", DW'(rvalid), '0);
    check("R8", "rdata oe off", rdata, '0);
    oe_n = 0; #1;
    check("R8", "rvalid oe on", DW'(rvalid), 1);
    check("R8", "rdata oe on", rdata, shadow[7]);
    oe_n = 1; tick("R8"); oe_n = 0;
    wr_ctl("R8", 10, pat(77)); tick("R8"); tick("R8");

    // R9: sleep ends a burst and keeps contents
    idle(); cpu_strb_n = 0; addr = 4'd12; tick("R9");
    idle(); sleep = 1; adv_n = 0; tick("R9"); tick("R9");
    idle(); cpu_strb_n = 0; tick("R9"); idle(); tick("R9");
    sleep = 0; tick("R10"); tick("R10");
    rd_ctl("R9", 12);
    rd_ctl("R9", 10);

    // R10: strobes in recovery window ignored and flagged
    idle(); sleep = 1; tick("R10"); sleep = 0;
    ctl_strb_n = 0; wr_all_n = 0; addr = 4'd1; wdata = '1; tick("R10");
    idle(); cpu_strb_n = 0; addr = 4'd1; tick("R10");
    idle(); cpu_strb_n = 0; addr = 4'd1; tick("R10");
    idle(); tick("R10"); tick("R10");
    rd_ctl("R10", 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule